// File: doc/BRIEF.md
# Macrocell Arithmetic/Logic Group

This block models a group of nine macrocells placed side by side, each with a small two-input arithmetic/logic unit in front of a storage element. Each cell forms two operands. Each operand is a wide OR of product terms. Some of those terms belong to the cell alone, and the rest are chosen from a pool shared by the whole group. The AND array that would produce those terms is outside the block: the terms arrive already evaluated, as plain bits.

Each cell works in one of two modes. In logic mode the cell applies any Boolean function of its two operands, chosen by a 4-entry truth table. In arithmetic mode it is one bit of an adder or subtractor. Its carry ripples upward to the next cell, and a lookahead network produces the carry out of the whole group directly. Each cell's result then goes either to a rising-edge register with asynchronous set and reset and a per-cell preload value, or straight to the output when the cell is configured transparent.

Top module: `mc_alu_group`

## Requirements
- R1: Operand A of cell i is the OR of private terms 0..3 of that cell (bits `privTerms[5i+0..5i+3]`) and of shared terms 0..3 whose bit in the cell's 4-bit field `d1ShareSel[4i+3:4i]` is 1. Bit k of the field selects shared term k.
- R2: Operand B of cell i is the OR of private term 4 (`privTerms[5i+4]`) and of shared terms 4..11 whose bit in `d2ShareSel[8i+7:8i]` is 1. Bit k of the field selects shared term 4+k. A shared term whose select bit is 0 has no effect on the operand.
- R3: A cell with `arithMode[i]`=0 produces bit `lutCfg[4i + {B,A}]`. For example, 0110 gives XOR, 1000 gives AND, 1010 passes A and 1100 passes B.
- R4: A cell with `arithMode[i]`=1 and `subMode`=0 produces A xor B xor its carry-in. Its carry-out is the majority of the three, and the lowest cell takes `carryIn` as its carry-in.
- R5: With `subMode`=1, arithmetic cells use the inverse of B, and the lowest cell's carry-in is 1 whatever `carryIn` is. The group then yields A − B, and a carry-out of 1 means there was no borrow.
- R6: A logic-mode cell passes the carry it receives to the next cell unchanged.
- R7: `groupCarryOut` comes from a group generate/propagate lookahead and always equals the carry rippled out of the top cell.
- R8: A cell with `transparent[i]`=0 and no asynchronous control active loads its result on each rising clock edge.
- R9: A cell with `transparent[i]`=1 drives its current result on `cellQ[i]` combinationally.
- R10: `asyncReset[i]` forces a registered cell to 0 without a clock. It wins over `asyncSet[i]`.
- R11: `asyncSet[i]` alone forces a registered cell to 1 without a clock.
- R12: While `rstN` is low, every register holds its `preload[i]` bit. To preload low, tie the bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rstN | input | 1 | Active-low initialisation, loads preload bits |
| privTerms | input | 45 | Five private product terms per cell |
| sharedTerms | input | 12 | Group-wide shared product terms |
| d1ShareSel | input | 36 | Per-cell selects of shared terms 0..3 into operand A |
| d2ShareSel | input | 72 | Per-cell selects of shared terms 4..11 into operand B |
| lutCfg | input | 36 | Per-cell 4-bit truth table for logic mode |
| arithMode | input | 9 | Per-cell arithmetic (1) or logic (0) mode |
| subMode | input | 1 | Group subtract when 1, add when 0 |
| carryIn | input | 1 | Carry into the lowest cell when adding |
| transparent | input | 9 | Per-cell register bypass |
| preload | input | 9 | Per-cell initialisation value |
| asyncSet | input | 9 | Per-cell asynchronous set |
| asyncReset | input | 9 | Per-cell asynchronous reset |
| cellQ | output | 9 | Per-cell output |
| groupCarryOut | output | 1 | Lookahead carry out of the group |

## Verification
The capture property assumes that configuration, term inputs and asynchronous controls change only between clock edges. It also assumes that no set or reset pulse begins and ends inside one clock period. The set/reset properties assume that a registered cell's override is read while the control is held. The stimulus drives every input just after the falling edge and holds each asynchronous control across whole periods. It changes a cell's mode only after checking that cell's result.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;

  // Group-level strobes from control to datapath.
  typedef struct packed {
    logic invertB;    // arithmetic cells use ~B
    logic carrySeed;  // carry into the lowest cell
  } alu_ctrl_t;

endpackage

// File: rtl/mc_operand_sum.sv
module mc_operand_sum #(
  parameter int N = 9,
  parameter int PRIV_TERMS = 5,
  parameter int SHARED_TERMS = 12,
  parameter int D1_SHARED = 4
) (
  input  logic [N*PRIV_TERMS-1:0]                 privTerms,
  input  logic [SHARED_TERMS-1:0]                 sharedTerms,
  input  logic [N*D1_SHARED-1:0]                  d1ShareSel,
  input  logic [N*(SHARED_TERMS-D1_SHARED)-1:0]   d2ShareSel,
  output logic [N-1:0]                            opA,
  output logic [N-1:0]                            opB
);
  localparam int D2_SHARED = SHARED_TERMS - D1_SHARED;

  logic [D1_SHARED-1:0] poolA;
  logic [D2_SHARED-1:0] poolB;
  assign poolA = sharedTerms[D1_SHARED-1:0];
  assign poolB = sharedTerms[SHARED_TERMS-1:D1_SHARED];

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [PRIV_TERMS-1:0] privSlice;
    assign privSlice = privTerms[i*PRIV_TERMS +: PRIV_TERMS];
    assign opA[i] = (|privSlice[PRIV_TERMS-2:0])
                  | (|(poolA & d1ShareSel[i*D1_SHARED +: D1_SHARED]));
    assign opB[i] = privSlice[PRIV_TERMS-1]
                  | (|(poolB & d2ShareSel[i*D2_SHARED +: D2_SHARED]));
  end
endmodule

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
  import mc_alu_pkg::*;
#(
  parameter int N = 9
) (
  input  logic         subMode,
  input  logic         carryIn,
  input  logic [N-1:0] arithMode,
  input  logic [N-1:0] transparent,
  output alu_ctrl_t    ctrl,
  output logic [N-1:0] arithEn,
  output logic [N-1:0] captureEn
);
  always_comb begin
    ctrl.invertB   = subMode;
    ctrl.carrySeed = subMode ? 1'b1 : carryIn;
  end

  assign arithEn   = arithMode;
  assign captureEn = ~transparent;
endmodule

// File: rtl/mc_alu_datapath.sv
module mc_alu_datapath
  import mc_alu_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  logic [4*N-1:0] lutCfg,
  input  logic [N-1:0]   arithEn,
  input  alu_ctrl_t      ctrl,
  output logic [N-1:0]   aluResult,
  output logic [N:0]     rippleCarry,
  output logic           groupCarry
);
  logic [N-1:0] gen;
  logic [N-1:0] prop;

  assign rippleCarry[0] = ctrl.carrySeed;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic       bEff;
    logic [3:0] cellLut;
    logic [1:0] lutSel;
    assign bEff    = opB[i] ^ (ctrl.invertB & arithEn[i]);
    assign cellLut = lutCfg[4*i +: 4];
    assign lutSel  = {opB[i], opA[i]};
    assign gen[i]  = arithEn[i] & opA[i] & bEff;
    assign prop[i] = ~arithEn[i] | (opA[i] ^ bEff);
    assign aluResult[i] = arithEn[i] ? (opA[i] ^ bEff ^ rippleCarry[i])
                                     : cellLut[lutSel];
    assign rippleCarry[i+1] = gen[i] | (prop[i] & rippleCarry[i]);
  end

  // Flat two-level lookahead across the group.
  always_comb begin
    logic grpG;
    logic grpP;
    grpG = 1'b0;
    grpP = &prop;
    for (int i = 0; i < N; i++) begin
      logic term;
      term = gen[i];
      for (int j = i + 1; j < N; j++) term = term & prop[j];
      grpG = grpG | term;
    end
    groupCarry = grpG | (grpP & ctrl.carrySeed);
  end
endmodule

// File: rtl/mc_cell_reg.sv
module mc_cell_reg #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] aluResult,
  input  logic [N-1:0] captureEn,
  input  logic [N-1:0] preload,
  input  logic [N-1:0] asyncSet,
  input  logic [N-1:0] asyncReset,
  output logic [N-1:0] cellQ
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic qReg;
    always_ff @(posedge clk or negedge rstN or posedge asyncReset[i] or posedge asyncSet[i]) begin
      if (!rstN)              qReg <= preload[i];
      else if (asyncReset[i]) qReg <= 1'b0;
      else if (asyncSet[i])   qReg <= 1'b1;
      else                    qReg <= aluResult[i];
    end

    always_comb begin
      if (!captureEn[i])      cellQ[i] = aluResult[i];
      else if (!rstN)         cellQ[i] = qReg;
      else if (asyncReset[i]) cellQ[i] = 1'b0;
      else if (asyncSet[i])   cellQ[i] = 1'b1;
      else                    cellQ[i] = qReg;
    end
  end
endmodule

// File: rtl/mc_alu_group.sv
module mc_alu_group
  import mc_alu_pkg::*;
#(
  parameter int N = 9,
  parameter int PRIV_TERMS = 5,
  parameter int SHARED_TERMS = 12,
  parameter int D1_SHARED = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [N*PRIV_TERMS-1:0]                privTerms,
  input  logic [SHARED_TERMS-1:0]                sharedTerms,
  input  logic [N*D1_SHARED-1:0]                 d1ShareSel,
  input  logic [N*(SHARED_TERMS-D1_SHARED)-1:0]  d2ShareSel,
  input  logic [4*N-1:0]                         lutCfg,
  input  logic [N-1:0]                           arithMode,
  input  logic                                   subMode,
  input  logic                                   carryIn,
  input  logic [N-1:0]                           transparent,
  input  logic [N-1:0]                           preload,
  input  logic [N-1:0]                           asyncSet,
  input  logic [N-1:0]                           asyncReset,
  output logic [N-1:0]                           cellQ,
  output logic                                   groupCarryOut
);
  alu_ctrl_t    ctrl;
  logic [N-1:0] arithEn;
  logic [N-1:0] captureEn;
  logic [N-1:0] opA;
  logic [N-1:0] opB;
  logic [N-1:0] aluResult;
  logic [N:0]   rippleCarry;

  mc_alu_ctrl #(.N(N)) ctrl_i (
    .subMode(subMode), .carryIn(carryIn), .arithMode(arithMode),
    .transparent(transparent), .ctrl(ctrl), .arithEn(arithEn),
    .captureEn(captureEn)
  );

  mc_operand_sum #(
    .N(N), .PRIV_TERMS(PRIV_TERMS), .SHARED_TERMS(SHARED_TERMS), .D1_SHARED(D1_SHARED)
  ) ops_i (
    .privTerms(privTerms), .sharedTerms(sharedTerms), .d1ShareSel(d1ShareSel),
    .d2ShareSel(d2ShareSel), .opA(opA), .opB(opB)
  );

  mc_alu_datapath #(.N(N)) dp_i (
    .opA(opA), .opB(opB), .lutCfg(lutCfg), .arithEn(arithEn), .ctrl(ctrl),
    .aluResult(aluResult), .rippleCarry(rippleCarry), .groupCarry(groupCarryOut)
  );

  mc_cell_reg #(.N(N)) reg_i (
    .clk(clk), .rstN(rstN), .aluResult(aluResult), .captureEn(captureEn),
    .preload(preload), .asyncSet(asyncSet), .asyncReset(asyncReset), .cellQ(cellQ)
  );
endmodule

// File: rtl/mc_alu_group_chk.sv
module mc_alu_group_chk #(
  parameter int N = 9
) (
  input logic         clk,
  input logic         rstN,
  input logic         subMode,
  input logic         carryIn,
  input logic [N-1:0] transparent,
  input logic [N-1:0] asyncSet,
  input logic [N-1:0] asyncReset,
  input logic [N-1:0] cellQ,
  input logic         groupCarryOut,
  input logic [N-1:0] aluResult,
  input logic [N:0]   rippleCarry
);
  logic [N-1:0] quietMask;
  assign quietMask = ~transparent & ~asyncSet & ~asyncReset;

  assert_lookahead_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    groupCarryOut == rippleCarry[N]);

  assert_sub_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    subMode |-> rippleCarry[0]);

  assert_add_seed_R4: assert property (@(posedge clk) disable iff (!rstN)
    !subMode |-> (rippleCarry[0] == carryIn));

  assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((cellQ ^ aluResult) & transparent) == '0);

  assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cellQ & asyncReset & ~transparent) == '0);

  assert_set_forces_R11: assert property (@(posedge clk) disable iff (!rstN)
    (~cellQ & asyncSet & ~asyncReset & ~transparent) == '0);

  assert_edge_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((cellQ ^ $past(aluResult)) & quietMask & $past(quietMask)) == '0));
endmodule

bind mc_alu_group mc_alu_group_chk #(.N(N)) chk_i (
  .clk(clk), .rstN(rstN), .subMode(subMode), .carryIn(carryIn),
  .transparent(transparent), .asyncSet(asyncSet), .asyncReset(asyncReset),
  .cellQ(cellQ), .groupCarryOut(groupCarryOut), .aluResult(aluResult),
  .rippleCarry(rippleCarry)
);

// File: tb/mc_alu_group_tb_top.sv
module mc_alu_group_tb_top;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rstN;
  logic [44:0]  privTerms;
  logic [11:0]  sharedTerms;
  logic [35:0]  d1ShareSel;
  logic [71:0]  d2ShareSel;
  logic [35:0]  lutCfg;
  logic [8:0]   arithMode;
  logic         subMode;
  logic         carryIn;
  logic [8:0]   transparent;
  logic [8:0]   preload;
  logic [8:0]   asyncSet;
  logic [8:0]   asyncReset;
  logic [8:0]   cellQ;
  logic         groupCarryOut;

  int checkCount = 0;
  int failCount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mc_alu_group dut_i (
    .clk(clk), .rstN(rstN), .privTerms(privTerms), .sharedTerms(sharedTerms),
    .d1ShareSel(d1ShareSel), .d2ShareSel(d2ShareSel), .lutCfg(lutCfg),
    .arithMode(arithMode), .subMode(subMode), .carryIn(carryIn),
    .transparent(transparent), .preload(preload), .asyncSet(asyncSet),
    .asyncReset(asyncReset), .cellQ(cellQ), .groupCarryOut(groupCarryOut)
  );

  // {sub, cin, A[8:0], B[8:0]}
  localparam logic [19:0] VEC [7] = '{
    {1'b0, 1'b0, 9'h0FF, 9'h001},
    {1'b0, 1'b1, 9'h1FF, 9'h000},
    {1'b0, 1'b0, 9'h1FF, 9'h1FF},
    {1'b0, 1'b1, 9'h155, 9'h0AA},
    {1'b1, 1'b0, 9'h005, 9'h003},
    {1'b1, 1'b1, 9'h003, 9'h005},
    {1'b1, 1'b0, 9'h000, 9'h000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // A[i] goes to private term (i%4) of cell i, B[i] to private term 4.
  task automatic setOps(input logic [8:0] a, input logic [8:0] b);
    privTerms = '0;
    for (int i = 0; i < N; i++) begin
      privTerms[i*5 + (i % 4)] = a[i];
      privTerms[i*5 + 4] = b[i];
    end
  endtask

  function automatic logic [9:0] expArith(input logic sub, input logic cin,
                                          input logic [8:0] a, input logic [8:0] b);
    if (sub) return {1'b0, a} + {1'b0, ~b} + 10'd1;
    return {1'b0, a} + {1'b0, b} + {9'd0, cin};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; privTerms = '0; sharedTerms = '0; d1ShareSel = '0; d2ShareSel = '0;
    lutCfg = '0; arithMode = '0; subMode = 1'b0; carryIn = 1'b0; transparent = '0;
    preload = 9'h0A5; asyncSet = '0; asyncReset = '0;

    // R12: preload during initialisation
    repeat (2) @(negedge clk);
    #2 check("R12 preload", 32'(cellQ), 32'h0A5);
    preload = 9'h15A;
    @(posedge clk); @(negedge clk);
    #2 check("R12 preload change", 32'(cellQ), 32'h15A);
    @(negedge clk);
    rstN = 1'b1;

    // Arithmetic vectors: transparent read, then registered capture
    for (int v = 0; v < 7; v++) begin
      logic [9:0] e;
      @(negedge clk);
      arithMode = '1; transparent = '1;
      subMode = VEC[v][19]; carryIn = VEC[v][18];
      setOps(VEC[v][17:9], VEC[v][8:0]);
      e = expArith(VEC[v][19], VEC[v][18], VEC[v][17:9], VEC[v][8:0]);
      #2;
      if (VEC[v][19]) check("R5 difference", 32'(cellQ), 32'(e[8:0]));
      else            check("R4 sum", 32'(cellQ), 32'(e[8:0]));
      check("R7 group carry", 32'(groupCarryOut), 32'(e[9]));
      @(negedge clk);
      transparent = '0;
      @(posedge clk); @(negedge clk);
      #2 check("R8 capture", 32'(cellQ), 32'(e[8:0]));
    end

    // R3: logic-mode truth tables, transparent
    @(negedge clk);
    arithMode = '0; transparent = '1; subMode = 1'b0; carryIn = 1'b0;
    setOps(9'h0F0, 9'h0CC);
    lutCfg = {9{4'b0110}};
    #2 check("R3 xor", 32'(cellQ), 32'h03C);
    lutCfg = {9{4'b1000}};
    #2 check("R3 and", 32'(cellQ), 32'h0C0);
    lutCfg = {9{4'b0111}};
    #2 check("R3 nand / R9 follow", 32'(cellQ), 32'h13F);

    // R1: shared term 2 into operand A of cell 3 only
    setOps(9'h000, 9'h000);
    lutCfg = {9{4'b1010}};
    sharedTerms = 12'h004;
    d1ShareSel = '0; d1ShareSel[3*4 + 2] = 1'b1;
    #2 check("R1 shared into A", 32'(cellQ), 32'h008);

    // R2: shared term 7 into operand B of cell 6, then deselected
    lutCfg = {9{4'b1100}};
    d1ShareSel = '0;
    sharedTerms = 12'h080;
    d2ShareSel = '0; d2ShareSel[6*8 + 3] = 1'b1;
    #2 check("R2 shared into B", 32'(cellQ), 32'h040);
    d2ShareSel = '0;
    #2 check("R2 unselected ignored", 32'(cellQ), 32'h000);
    sharedTerms = '0;

    // R6: carry passes through a logic-mode cell 4 (table all zero)
    @(negedge clk);
    arithMode = 9'h1EF; lutCfg = '0;
    setOps(9'h00F, 9'h001);
    #2 check("R6 carry pass", 32'(cellQ), 32'h020);
    check("R6 group carry", 32'(groupCarryOut), 32'h0);

    // R10 / R11: asynchronous set and reset on registered cell 2
    @(negedge clk);
    arithMode = '1; setOps(9'h000, 9'h000); transparent = '0;
    @(posedge clk); @(negedge clk);
    asyncSet[2] = 1'b1;
    #2 check("R11 set", 32'(cellQ[2]), 32'h1);
    @(negedge clk);
    asyncReset[2] = 1'b1;
    #2 check("R10 reset wins", 32'(cellQ[2]), 32'h0);
    @(negedge clk);
    asyncReset[2] = 1'b0;
    #2 check("R11 set after reset release", 32'(cellQ[2]), 32'h1);
    @(negedge clk);
    asyncSet[2] = 1'b0;
    @(posedge clk); @(negedge clk);
    #2 check("R8 capture after release", 32'(cellQ), 32'h000);

    done = 1;
    summary();
    $finish;
  end
endmodule